// File: doc/BRIEF.md
# Predicate-Aware Operand Forwarding and Hazard Control

This block is the combinational control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which every instruction carries a one-bit guard. It chooses where each of the two execute-stage source operands comes from: the result held in the execute/memory register, the result held in the memory/writeback register, or the value read from the register file. It also raises the load-use stall for decode, gates the guard and write bits that decode loads into the execute register during that stall, and gates the register-file write strobe in writeback.

An instruction whose guard is 0 still travels through every stage, but it is treated as a ghost. It never supplies a forwarded value, never stalls a younger instruction and never writes a register. Consumers then take their operand from an older live producer or from the register file. The guard is resolved by decode, so the stall logic can use it directly. The datapath, memory, branch handling and guard computation sit outside this block.

Top module: `pfw_hazard_unit`

## Requirements
- R1: `rf_we` is 1 exactly when the writeback instruction has write enable 1, guard 1 and a destination other than register 0.
- R2: When the execute/memory producer has write enable 1 and guard 1, and its nonzero destination equals an execute source, that source's select is 2'b10.
- R3: An execute/memory producer with guard 0 or write enable 0 never yields select 2'b10.
- R4: Without a live execute/memory match, a live matching memory/writeback producer (write enable 1, guard 1, nonzero destination) gives select 2'b01. Otherwise the select is 2'b00, meaning the register-file value.
- R5: When both forwarding registers hold live producers to the same source register, the execute/memory one wins (select 2'b10).
- R6: Source register 0 always gets select 2'b00, and a destination of 0 never causes a stall.
- R7: `stall` is 1 when the execute-stage instruction is a load with write enable 1 and guard 1 whose nonzero destination equals either decode source register. A non-load never stalls.
- R8: A load with guard 0 never raises `stall`, even when decode reads its destination.
- R9: While `stall` is 1, `idex_pred_d` and `idex_wen_d` are 0, so a bubble enters execute. Otherwise they equal `id_pred` and `id_wen`.
- R10: The two source selects are decided independently, so one cycle can forward different stages to operand A and operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_pred | input | 1 | Guard bit of the decode instruction |
| id_wen | input | 1 | Write enable of the decode instruction |
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage write enable |
| ex_pred | input | 1 | Execute-stage guard bit |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Execute/memory register destination |
| mem_wen | input | 1 | Execute/memory register write enable |
| mem_pred | input | 1 | Execute/memory register guard bit |
| wb_rd | input | 5 | Memory/writeback register destination |
| wb_wen | input | 1 | Memory/writeback register write enable |
| wb_pred | input | 1 | Memory/writeback register guard bit |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 memory/writeback, 10 execute/memory |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and the decode register, bubble execute |
| idex_pred_d | output | 1 | Guard bit to load into the execute register |
| idex_wen_d | output | 1 | Write enable to load into the execute register |
| rf_we | output | 1 | Gated register-file write strobe |

## Verification
The hardest case to reach is fallback past a ghost. The nearest producer matches the source register but has guard 0, and an older live producer of the same register sits behind it, so the select must skip to 2'b01 and not stop at 2'b10 or drop to 2'b00. The vector table drives this directly by giving the execute/memory and memory/writeback fields the same destination with opposite guards. Further rows pair a guarded-off load against a decode reader of its destination, which must not stall.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e [NSRC-1:0] sel_d;
        logic                stall_d;
        logic                rf_we_d;
        logic                idex_pred_d;
        logic                idex_wen_d;
    } hz_t;
endpackage

// File: rtl/pfw_operand.sv
module pfw_operand
    import pfw_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mem_rd,
    input  logic         mem_live,
    input  logic [W-1:0] wb_rd,
    input  logic         wb_live,
    output fwd_sel_e     sel
);
    logic hit_mem_d, hit_wb_d;

    always_comb begin
        hit_mem_d = mem_live && (mem_rd == src) && (src != '0);
        hit_wb_d  = wb_live  && (wb_rd  == src) && (src != '0);
        if (hit_mem_d)     sel = SEL_EXMEM;
        else if (hit_wb_d) sel = SEL_MEMWB;
        else               sel = SEL_RF;
    end

    always_comb begin
        p_zero_src_rf_r6: assert (src != '0 || sel == SEL_RF)
            else $error("register 0 forwarded");
        p_wb_only_when_live_r4: assert (sel != SEL_MEMWB || (wb_live && wb_rd == src))
            else $error("memwb select without live producer");
    end
endmodule

// File: rtl/pfw_stall.sv
module pfw_stall
    import pfw_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] id_rs1,
    input  logic [W-1:0] id_rs2,
    input  logic [W-1:0] ex_rd,
    input  logic         ex_load_live,
    output logic         stall
);
    logic rd_nz_d;

    always_comb begin
        rd_nz_d = (ex_rd != '0);
        stall   = ex_load_live && rd_nz_d && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    end

    always_comb begin
        p_stall_reads_dest_r7: assert (!stall || id_rs1 == ex_rd || id_rs2 == ex_rd)
            else $error("stall without matching reader");
        p_stall_nonzero_r6: assert (!stall || ex_rd != '0)
            else $error("stall on register 0");
    end
endmodule

// File: rtl/pfw_hazard_unit.sv
module pfw_hazard_unit
    import pfw_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic       id_pred,
    input  logic       id_wen,
    input  logic [4:0] ex_rs1,
    input  logic [4:0] ex_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_wen,
    input  logic       ex_pred,
    input  logic       ex_is_load,
    input  logic [4:0] mem_rd,
    input  logic       mem_wen,
    input  logic       mem_pred,
    input  logic [4:0] wb_rd,
    input  logic       wb_wen,
    input  logic       wb_pred,
    output logic [1:0] fwd_sel_a,
    output logic [1:0] fwd_sel_b,
    output logic       stall,
    output logic       idex_pred_d,
    output logic       idex_wen_d,
    output logic       rf_we
);
    logic [REG_W-1:0] ex_src [NSRC];
    fwd_sel_e         sel_w  [NSRC];
    logic             mem_live, wb_live, ex_load_live, stall_w;
    hz_t              hz_d;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    assign mem_live     = mem_wen && mem_pred;
    assign wb_live      = wb_wen && wb_pred;
    assign ex_load_live = ex_is_load && ex_wen && ex_pred;

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        pfw_operand #(.W(REG_W)) i_opnd (
            .src      (ex_src[g]),
            .mem_rd   (mem_rd),
            .mem_live (mem_live),
            .wb_rd    (wb_rd),
            .wb_live  (wb_live),
            .sel      (sel_w[g])
        );
    end

    pfw_stall #(.W(REG_W)) i_stall (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .ex_rd        (ex_rd),
        .ex_load_live (ex_load_live),
        .stall        (stall_w)
    );

    always_comb begin
        hz_d = '0;
        for (int i = 0; i < NSRC; i++) hz_d.sel_d[i] = sel_w[i];
        hz_d.stall_d     = stall_w;
        hz_d.rf_we_d     = wb_live && (wb_rd != '0);
        hz_d.idex_pred_d = id_pred && !stall_w;
        hz_d.idex_wen_d  = id_wen && !stall_w;
    end

    assign fwd_sel_a   = hz_d.sel_d[0];
    assign fwd_sel_b   = hz_d.sel_d[1];
    assign stall       = hz_d.stall_d;
    assign rf_we       = hz_d.rf_we_d;
    assign idex_pred_d = hz_d.idex_pred_d;
    assign idex_wen_d  = hz_d.idex_wen_d;

    always_comb begin
        p_rf_we_guarded_r1: assert (!rf_we || (wb_pred && wb_wen))
            else $error("write by guarded-off instruction");
        p_no_ghost_fwd_a_r3: assert (fwd_sel_a != 2'b10 || (mem_pred && mem_wen))
            else $error("ghost forwarded to A");
        p_no_ghost_fwd_b_r3: assert (fwd_sel_b != 2'b10 || (mem_pred && mem_wen))
            else $error("ghost forwarded to B");
        p_no_ghost_stall_r8: assert (!stall || (ex_pred && ex_is_load))
            else $error("stall by guarded-off load");
        p_bubble_r9: assert (!stall || (!idex_pred_d && !idex_wen_d))
            else $error("bubble not inserted");
    end
endmodule

// File: tb/test_pfw_hazard_unit.sv
module test_pfw_hazard_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_pred, id_wen, ex_wen, ex_pred, ex_is_load, mem_wen, mem_pred, wb_wen, wb_pred;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic stall, idex_pred_d, idex_wen_d, rf_we;

    int checks = 0;
    int errors = 0;

    pfw_hazard_unit i_pfw_hazard_unit (.*);

    typedef struct packed {
        logic [4:0] ers1, ers2, mrd; logic mw, mp;
        logic [4:0] wrd; logic ww, wp;
        logic [4:0] irs1, irs2; logic ip, iw;
        logic [4:0] erd; logic ew, ep, el;
        logic [1:0] xa, xb; logic xs, xrf;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 17;
    // ers1 ers2 mrd mw mp wrd ww wp irs1 irs2 ip iw erd ew ep el xa xb xs xrf tag
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd0},  // idle
        '{3,0,3,1,1, 0,0,0, 0,0,0,0, 0,0,0,0, 2'b10,2'b00,0,0, 8'd2},  // R2
        '{3,0,3,1,0, 0,0,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd3},  // R3 guard off
        '{3,0,3,0,1, 0,0,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd3},  // R3 wen off
        '{0,4,0,0,0, 4,1,1, 0,0,0,0, 0,0,0,0, 2'b00,2'b01,0,1, 8'd4},  // R4
        '{5,0,5,1,0, 5,1,1, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,0,1, 8'd4},  // R4 fallback past ghost
        '{6,0,6,1,1, 6,1,1, 0,0,0,0, 0,0,0,0, 2'b10,2'b00,0,1, 8'd5},  // R5
        '{0,0,0,1,1, 0,1,1, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd6},  // R6
        '{0,0,0,0,0, 7,1,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd1},  // R1 guard off
        '{0,0,0,0,0, 7,1,1, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,1, 8'd1},  // R1 write
        '{0,0,0,0,0, 7,0,1, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd1},  // R1 wen off
        '{0,0,0,0,0, 0,0,0, 8,0,1,1, 8,1,1,1, 2'b00,2'b00,1,0, 8'd7},  // R7 rs1, R9 bubble
        '{0,0,0,0,0, 0,0,0, 0,9,1,1, 9,1,1,1, 2'b00,2'b00,1,0, 8'd7},  // R7 rs2
        '{0,0,0,0,0, 0,0,0, 8,0,1,1, 8,1,0,1, 2'b00,2'b00,0,0, 8'd8},  // R8
        '{0,0,0,0,0, 0,0,0, 8,0,1,1, 8,1,1,0, 2'b00,2'b00,0,0, 8'd7},  // R7 non-load
        '{10,11,10,1,1, 11,1,1, 0,0,0,0, 0,0,0,0, 2'b10,2'b01,0,1, 8'd10}, // R10
        '{0,0,0,0,0, 0,0,0, 0,0,1,1, 0,1,1,1, 2'b00,2'b00,0,0, 8'd6}   // R6 stall
    };

    task automatic chk(input logic [7:0] tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ex_rs1 = v.ers1; ex_rs2 = v.ers2;
        mem_rd = v.mrd; mem_wen = v.mw; mem_pred = v.mp;
        wb_rd = v.wrd; wb_wen = v.ww; wb_pred = v.wp;
        id_rs1 = v.irs1; id_rs2 = v.irs2; id_pred = v.ip; id_wen = v.iw;
        ex_rd = v.erd; ex_wen = v.ew; ex_pred = v.ep; ex_is_load = v.el;
    endtask

    task automatic check_vec(input vec_t v);
        chk(v.tag, "sel_a", fwd_sel_a, v.xa);
        chk(v.tag, "sel_b", fwd_sel_b, v.xb);
        chk(v.tag, "stall", {1'b0, stall}, {1'b0, v.xs});
        chk(v.tag, "rf_we", {1'b0, rf_we}, {1'b0, v.xrf});
        chk(8'd9, "idex_pred", {1'b0, idex_pred_d}, {1'b0, v.ip & ~v.xs});
        chk(8'd9, "idex_wen", {1'b0, idex_wen_d}, {1'b0, v.iw & ~v.xs});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        // idle state: all outputs quiet
        drive(VECS[0]);
        @(negedge clk);
        check_vec(VECS[0]);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R4 both producers guarded off: both operands fall to register file
        v = '{12,12,12,1,0, 12,1,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,0,0, 8'd4};
        drive(v);
        @(negedge clk);
        check_vec(v);

        // R10 reversed: A from memwb, B from exmem
        v = '{13,14,14,1,1, 13,1,1, 0,0,0,0, 0,0,0,0, 2'b01,2'b10,0,1, 8'd10};
        drive(v);
        @(negedge clk);
        check_vec(v);

        // R8 guarded-off load read by both decode sources, decode bits pass through
        v = '{0,0,0,0,0, 0,0,0, 15,15,1,0, 15,1,0,1, 2'b00,2'b00,0,0, 8'd8};
        drive(v);
        @(negedge clk);
        check_vec(v);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule